// File: doc/BRIEF.md
# USB Root-Hub Port Status and Control Register

This block holds the status and control word for one downstream port of a full-speed and low-speed USB host controller. Software reads the word and writes it through a 16-bit register access. Each bit follows one of three rules. Read-only bits ignore writes. Read/write bits take the written value. Change flags are cleared by writing a one to them.

Device-side events update the same word. These are attach (which carries a low-speed flag), detach and remote wakeup. A change flag is raised only when the state it tracks actually moves. Attach, detach and a wakeup that is accepted each send a one-cycle resume request to the controller core.

When an event arrives in the same cycle as a software write, the event is applied on top of the merged write, so no change flag is lost. The read value is the register itself and is available combinationally.

Top module: `usb_rh_port_reg`

## Requirements
- R1: After synchronous reset the register reads 0x0080 and resume_req_o is low.
- R2: On a write, bits 0,1,3,4,5,7,8 (mask 0x01BB) keep their current value. All other bits take the written value.
- R3: After the write merge, a written one at bit 1 (connect change) or bit 3 (enable change) clears that bit. A written zero there leaves it unchanged.
- R4: Attach sets bit 0 (connected) and bit 1 (connect change). It sets bit 8 (low speed) when the attach low-speed flag is high and clears bit 8 otherwise.
- R5: Detach clears bit 0 and sets bit 1 only if bit 0 was set. Detach clears bit 2 (enabled) and sets bit 3 only if bit 2 was set. A bit that was already clear raises no flag.
- R6: Wakeup sets bit 6 (resume detected) and requests a resume only when bit 12 (suspended) is set and bit 6 is clear. Otherwise the register and resume_req_o are unaffected.
- R7: Attach and detach always request a resume. resume_req_o rises in the cycle after the event and stays high for exactly one cycle.
- R8: Events in the same cycle as a write are applied to the merged write value. When attach and detach arrive together, detach is applied first and attach second.
- R9: rd_data always equals the register contents, with no read side effects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | DATA_W | Software write value |
| attach_i | input | 1 | Device attach event |
| attach_low_speed_i | input | 1 | Attached device is low speed |
| detach_i | input | 1 | Device detach event |
| wakeup_i | input | 1 | Remote wakeup event |
| rd_data | output | DATA_W | Current register value |
| resume_req_o | output | 1 | One-cycle resume request to the controller core |

## Verification
The bench builds the block with the default DATA_W of 16. At that width every defined field, the read-only mask and the fixed bit 7 fall inside the word, so writes of all ones and all zeros exercise every bit class at once. Directed sequences cover these cases:
- attach at both speeds;
- detach with the port enabled and with it already cleared;
- wakeup with and without suspend;
- events that coincide with change-clearing writes.

// File: rtl/usb_rh_port_pkg.sv
package usb_rh_port_pkg;

    localparam int PORT_W = 16;

    localparam int B_CONN     = 0;
    localparam int B_CONN_CHG = 1;
    localparam int B_ENA      = 2;
    localparam int B_ENA_CHG  = 3;
    localparam int B_RES_DET  = 6;
    localparam int B_LOW_SPD  = 8;
    localparam int B_PRST     = 9;
    localparam int B_SUSP     = 12;

    localparam logic [PORT_W-1:0] RO_MASK  = 16'h01BB;
    localparam logic [PORT_W-1:0] W1C_MASK = (16'h1 << B_CONN_CHG) | (16'h1 << B_ENA_CHG);
    localparam logic [PORT_W-1:0] RST_VAL  = 16'h0080;

    typedef struct packed {
        logic attach;
        logic low_speed;
        logic detach;
        logic wakeup;
    } port_evt_t;

    function automatic logic [PORT_W-1:0] merge_write(
        input logic [PORT_W-1:0] cur,
        input logic [PORT_W-1:0] wd
    );
        logic [PORT_W-1:0] v;
        v = (cur & RO_MASK) | (wd & ~RO_MASK);
        v = v & ~(wd & W1C_MASK);
        return v;
    endfunction

endpackage

// File: rtl/rh_port_wr_merge.sv
module rh_port_wr_merge
    import usb_rh_port_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] cur,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] merged
);
    localparam int LOW_W = (DATA_W < PORT_W) ? DATA_W : PORT_W;

    logic [PORT_W-1:0] cur_lo;
    logic [PORT_W-1:0] wd_lo;
    logic [PORT_W-1:0] res_lo;

    always_comb begin
        cur_lo = '0;
        wd_lo  = '0;
        cur_lo[LOW_W-1:0] = cur[LOW_W-1:0];
        wd_lo[LOW_W-1:0]  = wr_data[LOW_W-1:0];
        res_lo = merge_write(cur_lo, wd_lo);
    end

    generate
        if (DATA_W > PORT_W) begin : g_wide
            always_comb begin
                merged = cur;
                if (wr_en) begin
                    merged[PORT_W-1:0]      = res_lo;
                    merged[DATA_W-1:PORT_W] = wr_data[DATA_W-1:PORT_W];
                end
            end
        end else begin : g_narrow
            always_comb begin
                merged = cur;
                if (wr_en) merged = res_lo[DATA_W-1:0];
            end
        end
    endgenerate
endmodule

// File: rtl/rh_port_evt_apply.sv
module rh_port_evt_apply
    import usb_rh_port_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] base,
    input  port_evt_t         evt,
    output logic [DATA_W-1:0] nxt,
    output logic              resume
);
    logic wake_ok;

    always_comb begin
        nxt = base;
        // detach first, so that a simultaneous attach wins the connect state
        if (evt.detach) begin
            if (nxt[B_CONN]) begin
                nxt[B_CONN]     = 1'b0;
                nxt[B_CONN_CHG] = 1'b1;
            end
            if (nxt[B_ENA]) begin
                nxt[B_ENA]     = 1'b0;
                nxt[B_ENA_CHG] = 1'b1;
            end
        end
        if (evt.attach) begin
            nxt[B_CONN]     = 1'b1;
            nxt[B_CONN_CHG] = 1'b1;
            nxt[B_LOW_SPD]  = evt.low_speed;
        end
        wake_ok = evt.wakeup && base[B_SUSP] && !base[B_RES_DET];
        if (wake_ok) nxt[B_RES_DET] = 1'b1;
        resume = evt.attach || evt.detach || wake_ok;
    end
endmodule

// File: rtl/usb_rh_port_reg.sv
module usb_rh_port_reg
    import usb_rh_port_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              attach_i,
    input  logic              attach_low_speed_i,
    input  logic              detach_i,
    input  logic              wakeup_i,
    output logic [DATA_W-1:0] rd_data,
    output logic              resume_req_o
);
    localparam logic [DATA_W-1:0] RST_W = DATA_W'(RST_VAL);

    logic [DATA_W-1:0] port_q;
    logic [DATA_W-1:0] after_wr;
    logic [DATA_W-1:0] after_evt;
    logic              resume_d;
    port_evt_t         evt;

    assign evt = '{attach:    attach_i,
                   low_speed: attach_low_speed_i,
                   detach:    detach_i,
                   wakeup:    wakeup_i};

    rh_port_wr_merge #(.DATA_W(DATA_W)) u_merge (
        .cur     (port_q),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .merged  (after_wr)
    );

    rh_port_evt_apply #(.DATA_W(DATA_W)) u_evt (
        .base   (after_wr),
        .evt    (evt),
        .nxt    (after_evt),
        .resume (resume_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            port_q       <= RST_W;
            resume_req_o <= 1'b0;
        end else begin
            port_q       <= after_evt;
            resume_req_o <= resume_d;
        end
    end

    assign rd_data = port_q;
endmodule

// File: rtl/usb_rh_port_chk.sv
module usb_rh_port_chk
    import usb_rh_port_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic              attach_i,
    input logic              detach_i,
    input logic              wakeup_i,
    input logic [DATA_W-1:0] rd_data,
    input logic              resume_req_o
);
    // R2: pure read-only bits hold across a write with no events
    a_r2_ro_hold: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !attach_i && !detach_i)
        |=> (rd_data[0] == $past(rd_data[0])) && (rd_data[8] == $past(rd_data[8]))
            && (rd_data[7] == $past(rd_data[7])));

    // R4: attach leaves the port connected with connect change set
    a_r4_attach: assert property (@(posedge clk) disable iff (rst)
        attach_i |=> (rd_data[B_CONN] && rd_data[B_CONN_CHG]));

    // R5: detach alone leaves the port disconnected and disabled
    a_r5_detach: assert property (@(posedge clk) disable iff (rst)
        (detach_i && !attach_i) |=> (!rd_data[B_CONN] && !rd_data[B_ENA]));

    // R5: no flag from a bit that was already clear
    a_r5_no_flag: assert property (@(posedge clk) disable iff (rst)
        (detach_i && !attach_i && !wr_en && !rd_data[B_CONN] && !rd_data[B_CONN_CHG])
        |=> !rd_data[B_CONN_CHG]);

    // R6: wakeup without suspend requests nothing
    a_r6_wake_ignored: assert property (@(posedge clk) disable iff (rst)
        (wakeup_i && !wr_en && !attach_i && !detach_i && !rd_data[B_SUSP])
        |=> !resume_req_o);

    // R6: accepted wakeup sets resume detect and requests resume
    a_r6_wake_taken: assert property (@(posedge clk) disable iff (rst)
        (wakeup_i && !wr_en && rd_data[B_SUSP] && !rd_data[B_RES_DET])
        |=> (rd_data[B_RES_DET] && resume_req_o));

    // R7: attach or detach always produces a resume request
    a_r7_evt_resume: assert property (@(posedge clk) disable iff (rst)
        (attach_i || detach_i) |=> resume_req_o);

    // R7: a lone request falls after one cycle
    a_r7_pulse: assert property (@(posedge clk) disable iff (rst)
        (resume_req_o && !attach_i && !detach_i && !wakeup_i) |=> !resume_req_o);
endmodule

bind usb_rh_port_reg usb_rh_port_chk #(.DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (wr_en),
    .attach_i     (attach_i),
    .detach_i     (detach_i),
    .wakeup_i     (wakeup_i),
    .rd_data      (rd_data),
    .resume_req_o (resume_req_o)
);

// File: tb/tb_usb_rh_port_reg.sv
module tb_usb_rh_port_reg;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         wr_en = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic         attach_i = 1'b0;
    logic         attach_low_speed_i = 1'b0;
    logic         detach_i = 1'b0;
    logic         wakeup_i = 1'b0;
    logic [W-1:0] rd_data;
    logic         resume_req_o;

    int checks = 0;
    int failures = 0;

    typedef struct {
        logic [W-1:0] val;
        logic         res;
        string        tag;
    } exp_t;
    exp_t sb[$];

    logic [W-1:0] model = 16'h0080;

    always #10 clk = ~clk;

    usb_rh_port_reg #(.DATA_W(W)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .attach_i(attach_i), .attach_low_speed_i(attach_low_speed_i),
        .detach_i(detach_i), .wakeup_i(wakeup_i),
        .rd_data(rd_data), .resume_req_o(resume_req_o)
    );

    // monitor: a quarter period after each rising edge
    always @(posedge clk) begin
        #5;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (rd_data !== e.val) begin
                failures++;
                $display("FAIL %s rd_data actual=%h expected=%h", e.tag, rd_data, e.val);
            end
            checks++;
            if (resume_req_o !== e.res) begin
                failures++;
                $display("FAIL %s resume actual=%b expected=%b", e.tag, resume_req_o, e.res);
            end
        end
    end

    // driver: applies one cycle of stimulus and pushes the expected result
    task automatic step(input logic we, input logic [W-1:0] wd,
                        input logic att, input logic ls, input logic det,
                        input logic wk, input string tag);
        logic [W-1:0] m;
        logic         r;
        @(negedge clk);
        wr_en = we; wr_data = wd; attach_i = att; attach_low_speed_i = ls;
        detach_i = det; wakeup_i = wk;
        m = model;
        if (we) begin
            m = (m & 16'h01BB) | (wd & ~16'h01BB);
            m = m & ~(wd & 16'h000A);
        end
        r = att | det;
        if (det) begin
            if (m[0]) begin m[0] = 1'b0; m[1] = 1'b1; end
            if (m[2]) begin m[2] = 1'b0; m[3] = 1'b1; end
        end
        if (att) begin m[0] = 1'b1; m[1] = 1'b1; m[8] = ls; end
        if (wk && m[12] && !m[6]) begin m[6] = 1'b1; r = 1'b1; end
        model = m;
        sb.push_back('{val: m, res: r, tag: tag});
    endtask

    task automatic idle(input string tag);
        step(1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b0, tag);
    endtask

    initial begin : watchdog
        #2000000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        checks++;
        if (rd_data !== 16'h0080 || resume_req_o !== 1'b0) begin
            failures++;
            $display("FAIL R1 reset actual=%h/%b expected=0080/0", rd_data, resume_req_o);
        end
        step(1'b1, 16'hFFFF, 0, 0, 0, 0, "R2 write ones");
        step(1'b1, 16'h0000, 0, 0, 0, 0, "R2 write zeros");
        step(1'b0, '0, 1'b1, 1'b1, 0, 0, "R4 attach low speed");
        idle("R7 single-cycle pulse");
        step(1'b1, 16'h0004, 0, 0, 0, 0, "R3 zero leaves change bit");
        step(1'b0, '0, 0, 0, 1'b1, 0, "R5 detach while enabled");
        step(1'b1, 16'h0002, 0, 0, 0, 0, "R3 clear connect change");
        step(1'b1, 16'h0008, 0, 0, 0, 0, "R3 clear enable change");
        step(1'b1, 16'h0183, 0, 0, 0, 0, "R2 read-only bits written");
        step(1'b0, '0, 0, 0, 1'b1, 0, "R5 detach with bits clear");
        step(1'b0, '0, 1'b1, 1'b0, 0, 0, "R4 attach full speed");
        step(1'b0, '0, 0, 0, 0, 1'b1, "R6 wakeup not suspended");
        step(1'b1, 16'h1000, 0, 0, 0, 0, "R2 set suspend");
        step(1'b0, '0, 0, 0, 0, 1'b1, "R6 wakeup while suspended");
        step(1'b0, '0, 0, 0, 0, 1'b1, "R6 wakeup already detected");
        step(1'b1, 16'h0002, 1'b1, 1'b1, 0, 0, "R8 attach during clearing write");
        step(1'b1, 16'h0004, 0, 0, 0, 0, "R2 enable port");
        step(1'b1, 16'h000E, 0, 0, 1'b1, 0, "R8 detach during clearing write");
        step(1'b0, '0, 1'b1, 1'b0, 1'b1, 0, "R8 attach and detach together");
        step(1'b1, 16'h1000, 0, 0, 0, 1'b1, "R8 wakeup with suspend write");
        idle("R9 read without side effects");
        idle("R9 read repeated");
        @(negedge clk);
        @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule